// File: doc/BRIEF.md
# Quadrature Encoder x4 Position Decoder

This block turns the two phase-shifted square waves of an incremental rotary encoder into a position count and a direction flag. Both encoder channels are first passed through a two-stage flip-flop synchroniser. The synchronised pair is then treated as a four-state phase machine with the states PH_00, PH_01, PH_11 and PH_10. Every edge on either channel moves the machine one state, so one full encoder cycle gives four counts.

Each clock, the decoder compares the phase it saw on the previous clock with the current phase. A move to the next state in the order PH_00 → PH_01 → PH_11 → PH_10 → PH_00 is a FORWARD step. A move to the preceding state in that ring is a BACKWARD step. An unchanged phase is a HOLD. A move to the opposite state, where both bits change at once, is an ILLEGAL jump. FORWARD adds one to a 16-bit wrapping counter and sets the direction flag. BACKWARD subtracts one and clears the flag. HOLD and ILLEGAL change neither.

The low 15 counter bits and the flag are packed onto two byte-wide output ports. The second port also has an enable output, which is held fully on. Encoder edges are assumed to be at least three clocks apart.

Top module: `qenc_x4`

## Requirements
- R1: A change on `enc_a`/`enc_b`, applied between clock edges, is first seen on the outputs after the third rising edge that follows it. After the second edge the outputs are still unchanged.
- R2: A FORWARD step adds one to the count and sets the direction flag to 1. FORWARD means {A,B} goes 00→01, 01→11, 11→10 or 10→00.
- R3: A BACKWARD step subtracts one from the count and clears the direction flag to 0. BACKWARD means {A,B} goes 01→00, 11→01, 10→11 or 00→10.
- R4: A HOLD (no change) or an ILLEGAL jump (00↔11, 01↔10) leaves both the count and the direction flag unchanged.
- R5: The 16-bit count wraps modulo 65536 in both directions. Stepping back from 0 gives 0xFFFF, which shows as 0x7FFF on the outputs. Stepping forward from 0xFFFF gives 0.
- R6: `out_lo[6:0]` carries count bits 6:0 and `out_lo[7]` carries the direction flag. `out_hi[7:0]` carries count bits 14:7. Count bit 15 appears on no output.
- R7: `out_hi_oe` is 8'hFF at all times.
- R8: A synchronous active-high `rst` does the following:
  - It clears the count, the direction flag and both synchroniser stages.
  - It counts no step while it is held.
  - After release, the synchronised pair starts from 00, so an encoder resting at 01 is counted as one FORWARD step.
- R9: The direction flag follows the most recent valid step only, not the sign or value of the count. For example, a BACKWARD step from a count of 4 gives a count of 3 with the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| out_lo | output | 8 | {direction flag, count[6:0]} |
| out_hi | output | 8 | count[14:7] |
| out_hi_oe | output | 8 | Output enable for `out_hi`, always all ones |

## Verification
Assertions check every cycle that each decoded FORWARD or BACKWARD step moves the count by exactly one and sets the flag to match. They also check that a cycle with no step leaves the count and flag alone, and that reset clears the outputs on the following clock. Several behaviours can only be shown by the bench's scenarios:
- the three-edge input latency;
- whether the full transition table is classified correctly, including illegal jumps;
- wrap-around at both ends;
- the bit packing across the two ports;
- the phantom step after reset with the encoder resting off 00.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_11 = 2'b11,
        PH_10 = 2'b10
    } phase_t;

    // successor of a phase in the forward ring
    function automatic phase_t fwd_of(phase_t p);
        unique case (p)
            PH_00: fwd_of = PH_01;
            PH_01: fwd_of = PH_11;
            PH_11: fwd_of = PH_10;
            PH_10: fwd_of = PH_00;
        endcase
    endfunction

    // predecessor of a phase in the forward ring
    function automatic phase_t bwd_of(phase_t p);
        unique case (p)
            PH_00: bwd_of = PH_10;
            PH_01: bwd_of = PH_00;
            PH_11: bwd_of = PH_01;
            PH_10: bwd_of = PH_11;
        endcase
    endfunction

endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= din;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/qenc_step.sv
module qenc_step
    import qenc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t cur,
    output logic   step_up,
    output logic   step_dn
);
    phase_t prev_q;

    // state register: follows the synchronised phase every clock, reset included
    always_ff @(posedge clk) begin
        prev_q <= cur;
    end

    // output process: classify the transition prev_q -> cur
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        if (!rst) begin
            unique case (prev_q)
                PH_00, PH_01, PH_11, PH_10: begin
                    step_up = (cur == fwd_of(prev_q));
                    step_dn = (cur == bwd_of(prev_q));
                end
            endcase
        end
    end
endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_up,
    input  logic             step_dn,
    output logic [CNT_W-1:0] cnt,
    output logic             dir
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dir <= 1'b0;
        end else if (step_up) begin
            cnt <= cnt + ONE;
            dir <= 1'b1;
        end else if (step_dn) begin
            cnt <= cnt - ONE;
            dir <= 1'b0;
        end
    end

    AST_UP_INC: assert property (@(posedge clk) disable iff (rst)
        step_up |=> (cnt == $past(cnt) + ONE) && dir); // R2
    AST_DN_DEC: assert property (@(posedge clk) disable iff (rst)
        step_dn |=> (cnt == $past(cnt) - ONE) && !dir); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step_up && !step_dn) |=> $stable(cnt) && $stable(dir)); // R4
endmodule

// File: rtl/qenc_x4.sv
module qenc_x4
    import qenc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    output logic [PORT_W-1:0] out_lo,
    output logic [PORT_W-1:0] out_hi,
    output logic [PORT_W-1:0] out_hi_oe
);
    localparam int LO_W   = PORT_W - 1;
    localparam int SHOW_W = LO_W + PORT_W;

    logic [1:0]       sync_ab;
    logic             step_up;
    logic             step_dn;
    logic [CNT_W-1:0] cnt;
    logic             dir;

    qenc_sync #(.W(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({enc_a, enc_b}),
        .dout (sync_ab)
    );

    qenc_step u_step (
        .clk     (clk),
        .rst     (rst),
        .cur     (phase_t'(sync_ab)),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    qenc_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .step_up (step_up),
        .step_dn (step_dn),
        .cnt     (cnt),
        .dir     (dir)
    );

    logic unused_msb;
    assign unused_msb = ^cnt[CNT_W-1:SHOW_W];

    assign out_lo    = {dir, cnt[LO_W-1:0]};
    assign out_hi    = cnt[SHOW_W-1:LO_W];
    assign out_hi_oe = '1;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (out_lo == '0) && (out_hi == '0)); // R8
    AST_NO_DOUBLE_STEP: assert property (@(posedge clk) disable iff (rst)
        !(step_up && step_dn)); // R4
endmodule

// File: tb/tb_qenc_x4.sv
module tb_qenc_x4;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enc_a = 1'b0;
    logic enc_b = 1'b0;
    logic [7:0] out_lo, out_hi, out_hi_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qenc_x4 dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .out_lo(out_lo), .out_hi(out_hi), .out_hi_oe(out_hi_oe)
    );

    // Each entry is {ab[1:0], req code[3:0], expected out_lo[7:0], expected out_hi[7:0]}.
    localparam logic [21:0] VEC [NVEC] = '{
        {2'b01, 4'd2, 8'h81, 8'h00},
        {2'b11, 4'd2, 8'h82, 8'h00},
        {2'b10, 4'd2, 8'h83, 8'h00},
        {2'b00, 4'd2, 8'h84, 8'h00},
        {2'b10, 4'd9, 8'h03, 8'h00},
        {2'b11, 4'd3, 8'h02, 8'h00},
        {2'b01, 4'd3, 8'h01, 8'h00},
        {2'b00, 4'd3, 8'h00, 8'h00},
        {2'b00, 4'd4, 8'h00, 8'h00},
        {2'b11, 4'd4, 8'h00, 8'h00},
        {2'b10, 4'd2, 8'h81, 8'h00},
        {2'b01, 4'd4, 8'h81, 8'h00},
        {2'b00, 4'd3, 8'h00, 8'h00},
        {2'b10, 4'd5, 8'h7F, 8'hFF},
        {2'b00, 4'd5, 8'h80, 8'h00}
    };

    function automatic string req_name(logic [3:0] c);
        case (c)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] lo_exp, logic [7:0] hi_exp);
        total++;
        if (out_lo !== lo_exp || out_hi !== hi_exp || out_hi_oe !== 8'hFF) begin
            bad++;
            $display("FAIL %s: actual lo=%h hi=%h oe=%h expected lo=%h hi=%h oe=ff",
                     tag, out_lo, out_hi, out_hi_oe, lo_exp, hi_exp);
        end
    endtask

    // drive a phase between edges, then let four edges pass
    task automatic move(logic [1:0] ab);
        {enc_a, enc_b} = ab;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset state", 8'h00, 8'h00);
        chk("R7 enable during reset", 8'h00, 8'h00);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 idle after release", 8'h00, 8'h00);

        // table walk: R2 R3 R4 R5 R9 and packing R6
        for (int i = 0; i < NVEC; i++) begin
            move(VEC[i][21:20]);
            chk($sformatf("%s/R6 vec %0d", req_name(VEC[i][19:16]), i),
                VEC[i][15:8], VEC[i][7:0]);
        end

        // R1 latency: count 0 dir 1, phase 00 -> 01
        {enc_a, enc_b} = 2'b01;
        repeat (2) @(negedge clk);
        chk("R1 unchanged after two edges", 8'h80, 8'h00);
        @(negedge clk);
        chk("R1 changed after third edge", 8'h81, 8'h00);
        repeat (2) @(negedge clk);

        // R6 carry into out_hi: 127 more forward steps to count 128
        for (int k = 1; k < 128; k++) begin
            case (k % 4)
                1: move(2'b11);
                2: move(2'b10);
                3: move(2'b00);
                default: move(2'b01);
            endcase
        end
        chk("R6 bit 7 on out_hi[0]", 8'h80, 8'h01);

        // R8 mid-run reset at phase 00
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 mid-run clear", 8'h00, 8'h00);
        {enc_a, enc_b} = 2'b01;
        repeat (4) @(negedge clk);
        chk("R8 no step while held", 8'h00, 8'h00);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 rest at 01 counts once after release", 8'h81, 8'h00);
        move(2'b11);
        chk("R2 after reset", 8'h82, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule